// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind a serial-bus slave engine in front of a small non-volatile store of 128 bytes. The engine hands it a starting byte address, then one strobe for each data byte it received, and finally a STOP indication. The block gathers those bytes in a four-slot page buffer. A per-slot valid mask records which slots were actually written.

On a STOP that closes a transfer holding at least one data byte, the block enters a self-timed program phase and raises `busy_o` for a fixed, parameterised number of clock cycles. The engine uses `busy_o` to withhold acknowledges. When the phase ends, all valid slots are written into the store at once, and `done_o` pulses for one cycle. A combinational read port lets the engine fetch stored bytes outside the program phase.

The controller is a three-state machine:
- **IDLE**: waits for an address load, which moves it to COLLECT.
- **COLLECT**: stores bytes. It stays in COLLECT when a new address is loaded, which discards the bytes held so far. It returns to IDLE on a START (abort) or on a STOP with an empty mask. It moves to PROGRAM on a STOP with a non-empty mask.
- **PROGRAM**: counts out the program time, then returns to IDLE and commits the page.

Top module: `pb_page_prog`

## Requirements
- R1: After reset every one of the 128 locations reads 0xFF, and `busy_o` and `done_o` are low.
- R2: `rd_data_o` shows the stored byte at `rd_addr_i` in the same cycle, with no clock edge needed.
- R3: An address load, one data byte and a STOP store that byte at the loaded address once the program phase ends. No other location changes.
- R4: Each accepted data byte goes to the slot given by the low two address bits, and only those two bits then advance by one, modulo 4. The upper five bits (bits 6..2) select the page and stay fixed, so a transfer that starts mid-page wraps to slot 0 of the same page.
- R5: When more than four bytes arrive in one transfer, a later byte overwrites the earlier byte in the same slot, and only the last value is committed.
- R6: Only slots that received a byte in the transfer are written. The other slots of the page keep their old contents.
- R7: A STOP after an address load with no data bytes starts no program phase. `busy_o` stays low and the store is unchanged.
- R8: `busy_o` rises in the cycle after the STOP is accepted and stays high for exactly PROG_CYCLES cycles. Reads during that window return the old contents.
- R9: While `busy_o` is high, address loads, data bytes, STOP and START are all ignored. Nothing they carry reaches the store, and they start no further program phase.
- R10: `done_o` is high for exactly one cycle, the first cycle with `busy_o` low after a program phase. The committed data is readable in that same cycle.
- R11: A START, or a new address load, during COLLECT discards every byte buffered so far. After a START, the following STOP programs nothing.
- R12: Data bytes and STOPs that arrive in IDLE, without a preceding address load, are ignored. When several controls arrive in the same COLLECT cycle, the priority is START, then address load, then STOP, then data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | Load starting address strobe |
| addr_i | input | 7 | Starting byte address |
| byte_vld_i | input | 1 | Received data byte strobe |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | Bus STOP seen |
| start_i | input | 1 | Bus START seen |
| rd_addr_i | input | 7 | Read address |
| rd_data_o | output | 8 | Stored byte at read address |
| busy_o | output | 1 | Program phase in progress |
| done_o | output | 1 | One-cycle pulse when the program phase ends |

## Verification
Most internal errors surface only at the end of a program phase. A wrong slot pointer or page register, a stale mask, or a lost abort stays hidden until `done_o`, when the read port shows a byte in the wrong location, an untouched slot overwritten, or an expected byte missing. A fault in the timer or the state register shows much sooner: `busy_o` is wrong within one cycle of the STOP, and the busy window has the wrong length. The bench therefore counts every busy window and sweeps all 128 locations after each group of transfers.

// File: rtl/pb_pkg.sv
package pb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2
    } pb_state_e;
endpackage

// File: rtl/pb_page_buf.sv
module pb_page_buf #(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 2,
    parameter int DATA_W = 8,
    localparam int SLOTS = 1 << PAGE_W,
    localparam int PG_W  = ADDR_W - PAGE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       load_addr,
    input  logic                    push,
    input  logic [DATA_W-1:0]       push_data,
    output logic [PG_W-1:0]         page_sel,
    output logic [SLOTS*DATA_W-1:0] slot_data,
    output logic [SLOTS-1:0]        slot_mask
);
    logic [PAGE_W-1:0] ptr;
    logic [DATA_W-1:0] slot_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            page_sel  <= '0;
            slot_mask <= '0;
            for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
        end else if (clr) begin
            slot_mask <= '0;
            for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
        end else if (load) begin
            page_sel  <= load_addr[ADDR_W-1:PAGE_W];
            ptr       <= load_addr[PAGE_W-1:0];
            slot_mask <= '0;
        end else if (push) begin
            slot_q[ptr]    <= push_data;
            slot_mask[ptr] <= 1'b1;
            ptr            <= ptr + 1'b1;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_flat
        assign slot_data[g*DATA_W +: DATA_W] = slot_q[g];
    end
endmodule

// File: rtl/pb_prog_timer.sv
module pb_prog_timer #(
    parameter int PROG_CYCLES = 1_000_000,
    localparam int CW = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic last
);
    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (kick) begin
            cnt <= '0;
            run <= 1'b1;
        end else if (run) begin
            if (last) run <= 1'b0;
            else      cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == CW'(PROG_CYCLES - 1));
endmodule

// File: rtl/pb_array.sv
module pb_array #(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 2,
    parameter int DATA_W = 8,
    localparam int SLOTS = 1 << PAGE_W,
    localparam int PG_W  = ADDR_W - PAGE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [PG_W-1:0]         page_sel,
    input  logic [SLOTS*DATA_W-1:0] slot_data,
    input  logic [SLOTS-1:0]        slot_mask,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((i / SLOTS) == int'(page_sel) && slot_mask[i % SLOTS])
                    mem[i] <= slot_data[(i % SLOTS)*DATA_W +: DATA_W];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pb_page_prog.sv
module pb_page_prog
    import pb_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int PAGE_W      = 2,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 1_000_000,
    localparam int SLOTS = 1 << PAGE_W,
    localparam int PG_W  = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              done_o
);
    pb_state_e state_q, state_d;

    logic                    buf_clr, buf_load, buf_push, prog_kick, prog_last;
    logic [PG_W-1:0]         page_sel;
    logic [SLOTS*DATA_W-1:0] slot_data;
    logic [SLOTS-1:0]        slot_mask;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and datapath controls
    always_comb begin
        state_d   = state_q;
        buf_clr   = 1'b0;
        buf_load  = 1'b0;
        buf_push  = 1'b0;
        prog_kick = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_load_i) begin
                    buf_load = 1'b1;
                    state_d  = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (start_i) begin
                    buf_clr = 1'b1;
                    state_d = ST_IDLE;
                end else if (addr_load_i) begin
                    buf_load = 1'b1;
                end else if (stop_i) begin
                    if (slot_mask != '0) begin
                        prog_kick = 1'b1;
                        state_d   = ST_PROGRAM;
                    end else begin
                        buf_clr = 1'b1;
                        state_d = ST_IDLE;
                    end
                end else if (byte_vld_i) begin
                    buf_push = 1'b1;
                end
            end
            ST_PROGRAM: begin
                if (prog_last) begin
                    buf_clr = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= (state_q == ST_PROGRAM) && prog_last;
    end

    assign busy_o = (state_q == ST_PROGRAM);

    pb_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .load      (buf_load),
        .load_addr (addr_i),
        .push      (buf_push),
        .push_data (byte_i),
        .page_sel  (page_sel),
        .slot_data (slot_data),
        .slot_mask (slot_mask)
    );

    pb_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (prog_kick),
        .last  (prog_last)
    );

    pb_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (prog_last),
        .page_sel  (page_sel),
        .slot_data (slot_data),
        .slot_mask (slot_mask),
        .rd_addr   (rd_addr_i),
        .rd_data   (rd_data_o)
    );
endmodule

// File: rtl/pb_page_prog_chk.sv
module pb_page_prog_chk #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 1_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              busy_o,
    input logic              done_o
);
    int unsigned busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_len <= 0;
        else if (busy_o) busy_len <= busy_len + 1;
        else             busy_len <= 0;
    end

    // R8: the busy window is exactly PROG_CYCLES long
    a_r8_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len == PROG_CYCLES));

    // R7: busy only begins right after a STOP
    a_r7_rise_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    // R10: done accompanies the falling edge of busy
    a_r10_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R10: done never overlaps busy and lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R8: store contents are frozen inside the busy window
    a_r8_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && $stable(rd_addr_i)) |-> $stable(rd_data_o));
endmodule

bind pb_page_prog pb_page_prog_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_i    (stop_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/sim_pb_page_prog.sv
module sim_pb_page_prog;
    localparam int CLK_PERIOD = 10;
    localparam int PROG = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [6:0] addr = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_d = '0;
    logic       stop = 1'b0;
    logic       start = 1'b0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_mem [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    pb_page_prog #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load), .addr_i(addr),
        .byte_vld_i(byte_vld), .byte_i(byte_d), .stop_i(stop), .start_i(start),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy), .done_o(done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] slot_addr(input logic [6:0] base, input int k);
        return {base[6:2], 2'(base[1:0] + k)};
    endfunction

    task automatic do_load(input logic [6:0] a);
        @(negedge clk); addr_load = 1'b1; addr = a;
        @(negedge clk); addr_load = 1'b0;
    endtask
    task automatic do_byte(input logic [7:0] d);
        @(negedge clk); byte_vld = 1'b1; byte_d = d;
        @(negedge clk); byte_vld = 1'b0;
    endtask
    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask
    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 128; i++) begin
            rd_addr = 7'(i); #1;
            check(req, rd_data, exp_mem[i]);
        end
        @(negedge clk);
    endtask

    // called right after the STOP has been taken; counts the busy window
    task automatic wait_prog(input bit inject, input logic [6:0] pend_a,
                             input logic [7:0] pend_d [4], input bit [3:0] pend_m);
        int c = 0;
        rd_addr = pend_a;
        while (busy && c < PROG + 8) begin
            if (c == 3) check("R8 old data during busy", rd_data, exp_mem[pend_a]);
            if (inject && c == 2) begin addr_load = 1'b1; addr = 7'h11; byte_vld = 1'b1; byte_d = 8'h5A; end
            if (inject && c == 3) begin addr_load = 1'b0; byte_vld = 1'b0; stop = 1'b1; start = 1'b1; end
            if (inject && c == 4) begin stop = 1'b0; start = 1'b0; end
            c++;
            @(negedge clk);
        end
        check("R8 busy length", c, PROG);
        for (int k = 0; k < 4; k++)
            if (pend_m[k]) exp_mem[{pend_a[6:2], 2'(k)}] = pend_d[k];
        check("R10 done with busy low", done, 1);
        rd_addr = pend_a; #1;
        check("R10 data visible at done", rd_data, exp_mem[pend_a]);
        @(negedge clk);
        check("R10 done single cycle", done, 0);
        check("R9 no second program phase", busy, 0);
    endtask

    // one transfer: load, n bytes, optional abort, STOP, then expected outcome
    task automatic txn(input logic [6:0] a, input int n, input bit abort, input bit inject);
        logic [7:0] pd [4];
        bit [3:0]   pm = '0;
        for (int k = 0; k < 4; k++) pd[k] = '0;
        do_load(a);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = 8'($urandom);
            logic [6:0] sa = slot_addr(a, i);
            do_byte(d);
            pd[sa[1:0]] = d;
            pm[sa[1:0]] = 1'b1;
        end
        if (abort) begin do_start(); pm = '0; end
        do_stop();
        if (pm != '0) begin
            check("R8 busy after stop", busy, 1);
            wait_prog(inject, a, pd, pm);
        end else begin
            check(abort ? "R11 abort no busy" : "R7 empty stop no busy", busy, 0);
            @(negedge clk);
            check("R7 still idle", busy, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7781));
        for (int i = 0; i < 128; i++) exp_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy at reset", busy, 0);
        check("R1 done at reset", done, 0);
        sweep("R1 R2 reset contents");

        // R3 single byte
        txn(7'h25, 1, 1'b0, 1'b0);
        sweep("R3 single byte write");
        // R4 wrap from mid page, R6 partial page keeps old bytes
        txn(7'h4B, 3, 1'b0, 1'b0);
        sweep("R4 R6 wrap within page");
        // R5 six bytes onto four slots
        txn(7'h60, 6, 1'b0, 1'b0);
        sweep("R5 overwrite on wrap");
        // R7 address-only transfer
        txn(7'h10, 0, 1'b0, 1'b0);
        // R11 abort by START
        txn(7'h30, 3, 1'b1, 1'b0);
        sweep("R11 abort leaves store");
        // R9 inputs during busy
        txn(7'h7E, 2, 1'b0, 1'b1);
        sweep("R9 inputs ignored while busy");
        // R12 bytes and stop without load in IDLE
        do_byte(8'h77);
        do_stop();
        check("R12 no busy from idle stop", busy, 0);
        // R11 address reload discards earlier bytes
        do_load(7'h40);
        do_byte(8'hAA);
        do_byte(8'hBB);
        begin
            logic [7:0] pd [4];
            pd[0] = '0; pd[1] = '0; pd[2] = 8'hC3; pd[3] = '0;
            do_load(7'h56);
            do_byte(8'hC3);
            do_stop();
            check("R11 busy after reload", busy, 1);
            wait_prog(1'b0, 7'h56, pd, 4'b0100);
        end
        sweep("R11 R12 reload and idle bytes");

        // constrained random transfers
        for (int t = 0; t < 40; t++) begin
            int n = int'($urandom_range(0, 6));
            bit ab = ($urandom_range(0, 7) == 0);
            txn(7'($urandom), n, ab, 1'b0);
            if (t % 8 == 7) sweep("R3 R4 R5 R6 random page");
        end
        sweep("R2 R6 final contents");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule